// File: doc/BRIEF.md
# Adaptive Delta Modulation Decoder

This block turns a received one-bit adaptive delta modulation stream back into a signed sample stream. Each bit arrives with a one-cycle valid strobe. A received 1 moves a running approximation up by the current step, and a received 0 moves it down by the same amount. The step adapts from bit to bit. It grows by one unit while the received bits repeat, and it shrinks by one unit when a bit differs from the one before. The step always lies between 1 and `LEVELS` units.

The approximation is captured into a hold register, so the value stays steady for the whole sample period. The held value then passes through a first-order low-pass filter that takes out the staircase steps. The shift count of the filter is a run-time input, so the corner frequency can be set to match the sample rate.

The decoder follows the same adaptation rule as the matching encoder's integrator. Fed the same bit stream, it gives the same sequence of approximations, and it starts from zero after reset.

Top module: `adm_decoder`

## Requirements
- R1: On each valid strobe, the accumulator rises by the current step when `bit_in` is 1 and falls by it when `bit_in` is 0. The step used is the one in effect before that bit's adaptation. The accumulator updates on the clock edge that samples the strobe.
- R2: The step is `level * STEP_UNIT`, where level runs from 1 to `LEVELS`. After each valid bit, level rises by 1 (capped at `LEVELS`) if the bit equals the previous valid bit, and otherwise falls by 1 (floored at 1). Internally, level is held as a thermometer code whose bit 0 is always set.
- R3: A synchronous reset with `rst_n` low clears the accumulator, the hold register and the filter output to 0. It also sets level to 1 and the stored previous bit to 0.
- R4: The hold register takes the accumulator value one clock after the accumulator updates. It changes at no other time.
- R5: The filter output updates one clock after the hold register, and only then, as y = y + ((x - y) >>> `filt_shift`), using 17-bit signed arithmetic. With `filt_shift` = 0 the output equals the held value.
- R6: The accumulator saturates at 32767 and at -32768 instead of wrapping.
- R7: While `bit_vld` is low, changes on `bit_in` have no effect on the accumulator, the step level or the outputs.
- R8: Valid strobes on consecutive clock cycles are each processed. The filter gets one update per strobe, in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_vld | input | 1 | Strobe marking a received bit |
| bit_in | input | 1 | Received bit; 1 means up, 0 means down |
| filt_shift | input | 4 | Filter shift count, 0 to 15 |
| acc_out | output | 16 | Raw signed accumulator |
| hold_out | output | 16 | Held signed sample |
| filt_out | output | 16 | Low-pass filtered signed output |

## Verification
A run of identical bits right after reset has exact expected values: 64, 128, 256, 448. These show whether the first bit is compared against a previous bit of 0, and whether the old step or the new step is applied. Alternating bits show the step shrinking, and a long run of 1s followed by a long run of 0s pushes the accumulator into both saturation limits. Spaced strobes are compared with back-to-back strobes to check the hold and filter pipeline. Toggling `bit_in` with no strobe, and then sending one bit, shows that neither the sum nor the step level moved.

// File: rtl/adm_pkg.sv
// Shared definitions for the adaptive delta modulation decoder.
// Assumes: all signed values are two's complement.
package adm_pkg;
    // Direction a received bit moves the approximation.
    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } step_dir_e;

    localparam int DEF_ACC_W     = 16;
    localparam int DEF_STEP_UNIT = 64;
    localparam int DEF_LEVELS    = 8;
endpackage

// File: rtl/adm_step_adapt.sv
// Step-size adaptation. Keeps the step level as a thermometer code and
// remembers the previous valid bit. Equal bits grow the code by one bit,
// and differing bits shrink it. Bit 0 stays set.
// Assumes: LEVELS >= 2.
module adm_step_adapt #(
    parameter int LEVELS = adm_pkg::DEF_LEVELS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_vld,
    input  logic              bit_in,
    output logic [LEVELS-1:0] therm
);
    logic prev_bit;
    logic grow;

    // Grow when the new bit repeats the previous one.
    always_comb grow = (bit_in == prev_bit);

    // Remember the last valid bit.
    always_ff @(posedge clk) begin
        if (!rst_n)       prev_bit <= 1'b0;
        else if (bit_vld) prev_bit <= bit_in;
    end

    // One thermometer stage per bit position.
    for (genvar i = 0; i < LEVELS; i++) begin : g_therm
        if (i == 0) begin : g_lsb
            // The lowest stage is always on.
            always_ff @(posedge clk) therm[0] <= 1'b1;
        end else if (i == LEVELS - 1) begin : g_msb
            // The top stage fills from below and empties to zero.
            always_ff @(posedge clk) begin
                if (!rst_n)       therm[i] <= 1'b0;
                else if (bit_vld) therm[i] <= grow ? therm[i-1] : 1'b0;
            end
        end else begin : g_mid
            // Middle stages shift up on grow and down on shrink.
            always_ff @(posedge clk) begin
                if (!rst_n)       therm[i] <= 1'b0;
                else if (bit_vld) therm[i] <= grow ? therm[i-1] : therm[i+1];
            end
        end
    end
endmodule

// File: rtl/adm_integrator.sv
// Accumulator. Adds or subtracts (level * STEP_UNIT) on each valid bit and
// saturates at the signed limits of ACC_W.
// Assumes: therm is a thermometer code that is valid in the strobe cycle.
module adm_integrator #(
    parameter int ACC_W     = adm_pkg::DEF_ACC_W,
    parameter int STEP_UNIT = adm_pkg::DEF_STEP_UNIT,
    parameter int LEVELS    = adm_pkg::DEF_LEVELS
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bit_vld,
    input  logic                    bit_in,
    input  logic [LEVELS-1:0]       therm,
    output logic signed [ACC_W-1:0] acc
);
    import adm_pkg::*;
    localparam int SUM_W = ACC_W + $clog2(LEVELS * STEP_UNIT + 1) + 1;
    localparam int CNT_W = $clog2(LEVELS + 1);
    localparam logic signed [SUM_W-1:0] MAX_EXT = SUM_W'((64'sd1 <<< (ACC_W - 1)) - 1);
    localparam logic signed [SUM_W-1:0] MIN_EXT = -MAX_EXT - SUM_W'(1);

    logic [CNT_W-1:0]        lvl;
    logic signed [SUM_W-1:0] step_s;
    logic signed [SUM_W-1:0] acc_ext;
    logic signed [SUM_W-1:0] nxt;
    step_dir_e               dir;

    // Count the set thermometer bits to get the level.
    always_comb begin
        lvl = '0;
        for (int i = 0; i < LEVELS; i++) lvl = lvl + CNT_W'(therm[i]);
    end

    // Step magnitude, direction and the unclamped next value.
    always_comb begin
        step_s  = SUM_W'(lvl) * SUM_W'(STEP_UNIT);
        dir     = step_dir_e'(bit_in);
        acc_ext = SUM_W'(acc);
        nxt     = (dir == DIR_UP) ? acc_ext + step_s : acc_ext - step_s;
    end

    // Register the clamped sum on each valid bit.
    always_ff @(posedge clk) begin
        if (!rst_n) acc <= '0;
        else if (bit_vld) begin
            if (nxt > MAX_EXT)      acc <= MAX_EXT[ACC_W-1:0];
            else if (nxt < MIN_EXT) acc <= MIN_EXT[ACC_W-1:0];
            else                    acc <= nxt[ACC_W-1:0];
        end
    end
endmodule

// File: rtl/adm_sample_hold.sv
// Hold stage. Copies the accumulator one clock after each update and flags
// that copy for the filter.
// Assumes: acc changes only on the edge that samples bit_vld.
module adm_sample_hold #(
    parameter int ACC_W = adm_pkg::DEF_ACC_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    acc_vld,
    input  logic signed [ACC_W-1:0] acc,
    output logic signed [ACC_W-1:0] hold,
    output logic                    hold_vld
);
    logic vld_d;

    // Delay the strobe to the cycle in which acc is updated.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_d <= 1'b0;
        else        vld_d <= acc_vld;
    end

    // Capture the accumulator and mark the new hold value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold     <= '0;
            hold_vld <= 1'b0;
        end else begin
            hold_vld <= vld_d;
            if (vld_d) hold <= acc;
        end
    end
endmodule

// File: rtl/adm_lpf.sv
// First-order low-pass filter: y += (x - y) >>> shift, once per enable.
// Assumes: the shift count is at most 15. The result always lies between
// x and y, so it fits in W bits.
module adm_lpf #(
    parameter int W = adm_pkg::DEF_ACC_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic [3:0]          shift,
    input  logic signed [W-1:0] x,
    output logic signed [W-1:0] y
);
    logic signed [W:0] diff;
    logic signed [W:0] delta;
    logic signed [W:0] sum;

    // Scaled error between input and output.
    always_comb begin
        diff  = (W+1)'(x) - (W+1)'(y);
        delta = diff >>> shift;
        sum   = (W+1)'(y) + delta;
    end

    // Apply one filter step per enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)  y <= '0;
        else if (en) y <= sum[W-1:0];
    end
endmodule

// File: rtl/adm_decoder.sv
// Top of the adaptive delta modulation decoder. Chains the step adapter,
// the accumulator, the hold stage and the smoothing filter.
// Assumes: bit_vld is a single-cycle strobe per received bit, and
// filt_shift is steady while samples move through the pipeline.
module adm_decoder #(
    parameter int ACC_W     = adm_pkg::DEF_ACC_W,
    parameter int STEP_UNIT = adm_pkg::DEF_STEP_UNIT,
    parameter int LEVELS    = adm_pkg::DEF_LEVELS
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bit_vld,
    input  logic                    bit_in,
    input  logic [3:0]              filt_shift,
    output logic signed [ACC_W-1:0] acc_out,
    output logic signed [ACC_W-1:0] hold_out,
    output logic signed [ACC_W-1:0] filt_out
);
    logic [LEVELS-1:0] step_therm;
    logic              hold_vld;

    adm_step_adapt #(.LEVELS(LEVELS)) i_adapt (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
        .therm(step_therm)
    );

    adm_integrator #(.ACC_W(ACC_W), .STEP_UNIT(STEP_UNIT), .LEVELS(LEVELS)) i_integ (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
        .therm(step_therm), .acc(acc_out)
    );

    adm_sample_hold #(.ACC_W(ACC_W)) i_hold (
        .clk(clk), .rst_n(rst_n), .acc_vld(bit_vld), .acc(acc_out),
        .hold(hold_out), .hold_vld(hold_vld)
    );

    adm_lpf #(.W(ACC_W)) i_lpf (
        .clk(clk), .rst_n(rst_n), .en(hold_vld), .shift(filt_shift),
        .x(hold_out), .y(filt_out)
    );
endmodule

// File: rtl/adm_decoder_chk.sv
// Property checker for adm_decoder, attached with bind.
module adm_decoder_chk #(
    parameter int ACC_W  = 16,
    parameter int LEVELS = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    bit_vld,
    input logic                    bit_in,
    input logic signed [ACC_W-1:0] acc_out,
    input logic signed [ACC_W-1:0] hold_out,
    input logic signed [ACC_W-1:0] filt_out,
    input logic [LEVELS-1:0]       step_therm
);
    localparam logic signed [ACC_W-1:0] MAXV = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] MINV = {1'b1, {(ACC_W-1){1'b0}}};

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (acc_out == '0 && hold_out == '0 && filt_out == '0)); // R3

    AST_RISE_ON_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && bit_in && acc_out != MAXV) |=> (acc_out > $past(acc_out))); // R1

    AST_FALL_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && !bit_in && acc_out != MINV) |=> (acc_out < $past(acc_out))); // R1

    AST_THERM_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (step_therm[0] && ((step_therm & (step_therm + 1'b1)) == '0))); // R2

    AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && bit_in && acc_out == MAXV) |=> (acc_out == MAXV)); // R6

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |=> $stable(acc_out)); // R7

    AST_HOLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && $past(rst_n)) |=> ##1 (hold_out == $past(acc_out))); // R4
endmodule

bind adm_decoder adm_decoder_chk #(.ACC_W(ACC_W), .LEVELS(LEVELS)) i_chk (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
    .acc_out(acc_out), .hold_out(hold_out), .filt_out(filt_out),
    .step_therm(step_therm)
);

// File: tb/test_adm_decoder.sv
// Directed bench for adm_decoder, with one task per scenario.
module test_adm_decoder;
    localparam int UNIT = 64;
    localparam int LV   = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_vld = 1'b0;
    logic       bit_in = 1'b0;
    logic [3:0] filt_shift = 4'd2;
    logic signed [15:0] acc_out, hold_out, filt_out;

    int n_chk = 0;
    int n_fail = 0;
    int m_acc, m_hold, m_filt, m_lvl, m_prev;
    bit done = 0;

    adm_decoder i_adm_decoder (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
        .filt_shift(filt_shift), .acc_out(acc_out), .hold_out(hold_out),
        .filt_out(filt_out)
    );

    always #2 clk = ~clk;

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int sat(int v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    // Model one valid bit, including its hold and filter stages.
    task automatic model_bit(int b);
        m_acc = sat(m_acc + (b != 0 ? m_lvl * UNIT : -m_lvl * UNIT));
        if (b == m_prev) m_lvl = (m_lvl < LV) ? m_lvl + 1 : LV;
        else             m_lvl = (m_lvl > 1) ? m_lvl - 1 : 1;
        m_prev = b;
        m_hold = m_acc;
        m_filt = m_filt + ((m_hold - m_filt) >>> int'(filt_shift));
    endtask

    task automatic send(int b);
        @(negedge clk);
        bit_vld = 1'b1;
        bit_in  = (b != 0);
        @(negedge clk);
        bit_vld = 1'b0;
        model_bit(b);
    endtask

    task automatic settle_check(string tag);
        repeat (3) @(negedge clk);
        chk({tag, " R1 acc"}, int'(acc_out), m_acc);
        chk({tag, " R4 hold"}, int'(hold_out), m_hold);
        chk({tag, " R5 filt"}, int'(filt_out), m_filt);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_acc = 0; m_hold = 0; m_filt = 0; m_lvl = 1; m_prev = 0;
        chk("R3 acc reset", int'(acc_out), 0);
        chk("R3 hold reset", int'(hold_out), 0);
        chk("R3 filt reset", int'(filt_out), 0);
    endtask

    // R2: a run of ones after reset gives 64, 128, 256, 448.
    task automatic t_ramp();
        int exp_v[4] = '{64, 128, 256, 448};
        for (int i = 0; i < 4; i++) begin
            send(1);
            repeat (2) @(negedge clk);
            chk("R2 ramp step", int'(acc_out), exp_v[i]);
        end
        settle_check("ramp");
    endtask

    // R2: alternating bits shrink the step toward one unit.
    task automatic t_alternate();
        for (int i = 0; i < 6; i++) begin
            send(i % 2);
            settle_check("R2 alternate");
        end
    endtask

    // R4 and R5: stage timing after a single strobe.
    task automatic t_pipe_timing();
        int old_acc = m_acc;
        int old_filt = m_filt;
        @(negedge clk);
        bit_vld = 1'b1; bit_in = 1'b0;
        @(negedge clk);
        bit_vld = 1'b0;
        model_bit(0);
        chk("R1 acc after one edge", int'(acc_out), m_acc);
        chk("R4 hold not yet moved", int'(hold_out), old_acc);
        @(negedge clk);
        chk("R4 hold one edge later", int'(hold_out), m_acc);
        chk("R5 filt not yet moved", int'(filt_out), old_filt);
        @(negedge clk);
        chk("R5 filt two edges later", int'(filt_out), m_filt);
    endtask

    // R7: toggling bit_in without a strobe changes nothing.
    task automatic t_idle();
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            bit_in = ~bit_in;
        end
        chk("R7 acc idle", int'(acc_out), m_acc);
        chk("R7 hold idle", int'(hold_out), m_hold);
        chk("R7 filt idle", int'(filt_out), m_filt);
        send(1);
        settle_check("R7 level kept");
    endtask

    // R5: a shift of zero passes the held value straight through.
    task automatic t_filter();
        filt_shift = 4'd0;
        send(1);
        settle_check("R5 shift0");
        chk("R5 shift0 equals hold", int'(filt_out), int'(hold_out));
        filt_shift = 4'd5;
        for (int i = 0; i < 5; i++) send(0);
        settle_check("R5 shift5");
        filt_shift = 4'd2;
    endtask

    // R8: back-to-back strobes.
    task automatic t_burst();
        int pat[10] = '{1, 1, 0, 1, 1, 1, 0, 0, 0, 1};
        @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            bit_vld = 1'b1;
            bit_in  = (pat[i] != 0);
            @(negedge clk);
            model_bit(pat[i]);
        end
        bit_vld = 1'b0;
        settle_check("R8 burst");
    endtask

    // R6: saturate high, then saturate low.
    task automatic t_sat();
        for (int i = 0; i < 80; i++) send(1);
        settle_check("R6 high");
        chk("R6 clamp max", int'(acc_out), 32767);
        for (int i = 0; i < 160; i++) send(0);
        settle_check("R6 low");
        chk("R6 clamp min", int'(acc_out), -32768);
    endtask

    initial begin
        t_reset();
        t_ramp();
        t_alternate();
        t_pipe_timing();
        t_idle();
        t_filter();
        t_burst();
        t_sat();
        t_reset();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(negedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule